// File: doc/BRIEF.md
# Execute-Stage Integer ALU with Byte Immediates

This block is the arithmetic and logic stage of a small integer core whose 32-bit instructions hold four one-byte fields: the opcode in the top byte, then the destination, then source A, then either source B or an 8-bit immediate. The surrounding pipeline decodes register numbers, reads the register file and hands the ALU the opcode, the two source values and the immediate byte. One clock later the ALU returns a result word and a write-enable that tells the writeback stage whether to update the destination.

The operation set has eight two-operand operations (add, subtract, and-not, reverse subtract, and, or, nor, xor). Each comes in an immediate form, where the zero-extended byte is the second operand, and in a register form. There are also a right rotate, three shifts with the count taken from the immediate, and two partial loads. These loads keep the low 16 or low 8 bits of the source and place the immediate directly above them.

The output stage is a two-state machine. `S_IDLE` means the output register holds no operation. `S_LIVE` means it holds the result of the operation accepted on the previous edge. The transition `accept` (in_valid high) moves it to or keeps it in `S_LIVE`. The transition `drain` (in_valid low) moves it to or keeps it in `S_IDLE`. Reset forces `S_IDLE`.

Top module: `exec_alu`

## Requirements
- R1: The outputs are registered with a latency of one cycle: out_valid equals in_valid of the previous edge. While rst_n is low, out_valid, wr_en and result are all zero.
- R2: Opcodes 0x00 to 0x07 use the immediate, zero-extended to 32 bits, as the second operand Y, with X = opnd_a. In that order they compute X+Y, X−Y, X&~Y, Y−X, X&Y, X|Y, ~(X|Y) and X^Y. wr_en is 1.
- R3: The subtractions wrap modulo 2^32. Opcode 0x01 gives A−imm, 0x03 gives imm−A, 0x11 gives A−B and 0x13 gives B−A.
- R4: Opcodes 0x10 to 0x17 perform the same eight operations with Y = opnd_b, and wr_en is 1. For these opcodes imm has no effect.
- R5: And-not (0x02, 0x12) gives the first operand ANDed with the bitwise complement of the second.
- R6: Opcode 0x44 rotates opnd_a right by the count, so bit i of the result is bit (i+count) mod 32 of opnd_a.
- R7: Opcode 0x45 shifts opnd_a left with zero fill. Opcode 0x46 shifts it right and fills with copies of bit 31. Opcode 0x47 shifts it right with zero fill.
- R8: For 0x44 to 0x47 the count is imm[4:0], and imm[7:5] has no effect.
- R9: Opcode 0x40 gives {8'h00, imm, opnd_a[15:0]}.
- R10: Opcode 0x4B gives {16'h0000, imm, opnd_a[7:0]}.
- R11: Every opcode not listed above gives wr_en = 0 and result = 0, with out_valid still 1.
- R12: A cycle with in_valid low gives out_valid = 0, wr_en = 0 and result = 0, whatever the opcode and operands.
- R13: For the immediate, rotate, shift and merge opcodes, opnd_b has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 8 | Opcode byte |
| opnd_a | input | 32 | First source value |
| opnd_b | input | 32 | Second source value (register forms) |
| imm | input | 8 | Immediate byte |
| out_valid | output | 1 | Result stage holds an operation |
| wr_en | output | 1 | Destination write requested |
| result | output | 32 | Operation result |

## Verification
The bench builds the block with its default parameters: 32-bit data, which gives a 5-bit shift count, and 8-bit opcode and immediate fields. At this size all 256 opcode values can be swept under several operand and immediate patterns, so every unrecognised code is seen as well as the valid ones. Every rotate and shift count from 0 to 31 is also covered, with the upper immediate bits set so that masking of the count is exercised.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_IMM,
        K_REG,
        K_SHIFT,
        K_MERGE
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [2:0] sel;
    } op_dec_t;

    typedef enum logic {
        S_IDLE,
        S_LIVE
    } stage_e;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] op,
    output op_dec_t         dec
);
    always_comb begin
        dec.kind = K_NONE;
        dec.sel  = op[2:0];
        if (op[OP_W-1:3] == '0) begin
            dec.kind = K_IMM;
        end else if (op[OP_W-1:3] == 2) begin
            dec.kind = K_REG;
        end else if (op[OP_W-1:2] == 6'h11) begin
            dec.kind = K_SHIFT;
            dec.sel  = {1'b0, op[1:0]};
        end else if (op == 8'h40) begin
            dec.kind = K_MERGE;
            dec.sel  = 3'd0;
        end else if (op == 8'h4B) begin
            dec.kind = K_MERGE;
            dec.sel  = 3'd1;
        end
    end
endmodule

// File: rtl/alu_logic8.sv
module alu_logic8 #(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        sel,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output logic [DATA_W-1:0] z
);
    always_comb begin
        unique case (sel)
            3'd0: z = x + y;
            3'd1: z = x - y;
            3'd2: z = x & ~y;
            3'd3: z = y - x;
            3'd4: z = x & y;
            3'd5: z = x | y;
            3'd6: z = ~(x | y);
            default: z = x ^ y;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic [2:0]        sel,
    input  logic              merge,
    input  logic [DATA_W-1:0] x,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] z
);
    localparam int CNT_W   = $clog2(DATA_W);
    localparam int HI_POS  = 16;
    localparam int LO_POS  = 8;

    logic [CNT_W-1:0]    cnt;
    logic [2*DATA_W-1:0] dbl;
    logic [DATA_W-1:0]   rot;
    logic [DATA_W-1:0]   imm_x;
    logic [DATA_W-1:0]   hi_mask;
    logic [DATA_W-1:0]   lo_mask;

    assign cnt     = imm[CNT_W-1:0];
    assign dbl     = {x, x} >> cnt;
    assign rot     = dbl[DATA_W-1:0];
    assign imm_x   = {{(DATA_W-IMM_W){1'b0}}, imm};

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_mask
            assign hi_mask[i] = (i < HI_POS);
            assign lo_mask[i] = (i < LO_POS);
        end
    endgenerate

    always_comb begin
        if (merge) begin
            z = sel[0] ? ((x & lo_mask) | (imm_x << LO_POS))
                       : ((x & hi_mask) | (imm_x << HI_POS));
        end else begin
            unique case (sel[1:0])
                2'd0: z = rot;
                2'd1: z = x << cnt;
                2'd2: z = $unsigned($signed(x) >>> cnt);
                default: z = x >> cnt;
            endcase
        end
    end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OP_W   = 8,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm,
    output logic              out_valid,
    output logic              wr_en,
    output logic [DATA_W-1:0] result
);
    op_dec_t           dec;
    logic [DATA_W-1:0] y_sel;
    logic [DATA_W-1:0] logic_z;
    logic [DATA_W-1:0] shift_z;
    logic [DATA_W-1:0] next_res;
    logic              next_we;
    stage_e            state_q, state_d;
    logic [DATA_W-1:0] res_q;
    logic              we_q;

    alu_decode #(.OP_W(OP_W)) u_dec (
        .op  (op),
        .dec (dec)
    );

    assign y_sel = (dec.kind == K_REG) ? opnd_b
                                       : {{(DATA_W-IMM_W){1'b0}}, imm};

    alu_logic8 #(.DATA_W(DATA_W)) u_logic (
        .sel (dec.sel),
        .x   (opnd_a),
        .y   (y_sel),
        .z   (logic_z)
    );

    alu_shift #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_shift (
        .sel   (dec.sel),
        .merge (dec.kind == K_MERGE),
        .x     (opnd_a),
        .imm   (imm),
        .z     (shift_z)
    );

    always_comb begin
        unique case (dec.kind)
            K_IMM, K_REG:     begin next_res = logic_z; next_we = 1'b1; end
            K_SHIFT, K_MERGE: begin next_res = shift_z; next_we = 1'b1; end
            default:          begin next_res = '0;      next_we = 1'b0; end
        endcase
    end

    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = in_valid ? S_LIVE : S_IDLE;
            S_LIVE:  state_d = in_valid ? S_LIVE : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            we_q  <= 1'b0;
        end else if (in_valid) begin
            res_q <= next_res;
            we_q  <= next_we;
        end else begin
            res_q <= '0;
            we_q  <= 1'b0;
        end
    end

    assign out_valid = (state_q == S_LIVE);
    assign wr_en     = we_q;
    assign result    = res_q;
endmodule

// File: rtl/exec_alu_chk.sv
module exec_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [7:0]  op,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [7:0]  imm,
    input logic        out_valid,
    input logic        wr_en,
    input logic [31:0] result
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && result == 32'h0));

    a_r11_no_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> result == 32'h0);

    a_r2_imm_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[7:3] == 5'h00) |=> wr_en);

    a_r9_low_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 8'h40) |=> (result[15:0] == $past(opnd_a[15:0])
                                       && result[23:16] == $past(imm)));

    a_r4_reg_or: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 8'h15) |=> result == ($past(opnd_a) | $past(opnd_b)));
endmodule

bind exec_alu exec_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .imm       (imm),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .result    (result)
);

// File: tb/sim_exec_alu.sv
module sim_exec_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  op = 8'h00;
    logic [31:0] opnd_a = 32'h0;
    logic [31:0] opnd_b = 32'h0;
    logic [7:0]  imm = 8'h00;
    logic        out_valid;
    logic        wr_en;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    exec_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm),
        .out_valid(out_valid), .wr_en(wr_en), .result(result)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [7:0] o);
        if (o == 8'h01 || o == 8'h03 || o == 8'h11 || o == 8'h13) return "R3";
        if (o == 8'h02 || o == 8'h12) return "R5";
        if (o[7:3] == 5'h00) return "R2";
        if (o[7:3] == 5'h02) return "R4";
        if (o == 8'h44) return "R6";
        if (o >= 8'h45 && o <= 8'h47) return "R7";
        if (o == 8'h40) return "R9";
        if (o == 8'h4B) return "R10";
        return "R11";
    endfunction

    function automatic logic [32:0] model(input logic [7:0] o, input logic [31:0] a,
                                          input logic [31:0] b, input logic [7:0] i);
        logic [31:0] y;
        logic [31:0] r;
        int n;
        n = int'(i % 32);
        y = (o[7:3] == 5'h02) ? b : {24'h0, i};
        if (o[7:3] == 5'h00 || o[7:3] == 5'h02) begin
            case (o[2:0])
                3'd0: r = a + y;
                3'd1: r = a - y;
                3'd2: r = a & (32'hFFFF_FFFF ^ y);
                3'd3: r = y - a;
                3'd4: r = a & y;
                3'd5: r = a | y;
                3'd6: r = 32'hFFFF_FFFF ^ (a | y);
                default: r = a ^ y;
            endcase
            return {1'b1, r};
        end
        case (o)
            8'h44: begin
                for (int k = 0; k < 32; k++) r[k] = a[(k + n) % 32];
                return {1'b1, r};
            end
            8'h45: return {1'b1, 32'(a * (33'd1 << n))};
            8'h46: begin
                for (int k = 0; k < 32; k++) r[k] = (k + n > 31) ? a[31] : a[k + n];
                return {1'b1, r};
            end
            8'h47: return {1'b1, 32'(a / (33'd1 << n))};
            8'h40: return {1'b1, 8'h00, i, a[15:0]};
            8'h4B: return {1'b1, 16'h0000, i, a[7:0]};
            default: return 33'h0;
        endcase
    endfunction

    task automatic run_one(input logic [7:0] o, input logic [31:0] a,
                           input logic [31:0] b, input logic [7:0] i, input string tag);
        logic [32:0] e;
        @(negedge clk);
        in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b; imm = i;
        e = model(o, a, b, i);
        @(negedge clk);
        chk({tag, " out_valid"}, {31'h0, out_valid}, 32'h1);
        chk({tag, " wr_en"}, {31'h0, wr_en}, {31'h0, e[32]});
        chk({tag, " result"}, result, e[31:0]);
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] av [4];
        logic [31:0] bv [4];
        logic [7:0]  iv [4];
        av[0] = 32'h0000_0000; bv[0] = 32'hFFFF_FFFF; iv[0] = 8'h00;
        av[1] = 32'hFFFF_FFFF; bv[1] = 32'h0000_0001; iv[1] = 8'hFF;
        av[2] = 32'h8000_0001; bv[2] = 32'h7FFF_FFFE; iv[2] = 8'h85;
        av[3] = 32'h1234_5678; bv[3] = 32'h9ABC_DEF0; iv[3] = 8'h3C;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", {31'h0, out_valid}, 32'h0);
        chk("R1 reset wr_en", {31'h0, wr_en}, 32'h0);
        chk("R1 reset result", result, 32'h0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6 R7 R9 R10 R11 R13: full opcode sweep
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 256; o++) begin
                run_one(8'(o), av[s], bv[s], iv[s], tag_of(8'(o)));
            end
        end

        // R13: opnd_b varied on immediate-form opcodes; R4: imm varied on register forms
        for (int o = 0; o < 8; o++) begin
            run_one(8'(o), 32'hCAFE_0042, 32'h5555_AAAA, 8'h9D, "R13");
            run_one(8'(o), 32'hCAFE_0042, 32'hAAAA_5555, 8'h9D, "R13");
            run_one(8'(o + 16), 32'hCAFE_0042, 32'h0F0F_F0F0, 8'h00, "R4");
            run_one(8'(o + 16), 32'hCAFE_0042, 32'h0F0F_F0F0, 8'hEE, "R4");
        end

        // R8: every count with the upper immediate bits set
        for (int o = 8'h44; o <= 8'h47; o++) begin
            for (int n = 0; n < 32; n++) begin
                run_one(8'(o), 32'h8765_4321, 32'h0, 8'(n) | 8'hE0, "R8");
                run_one(8'(o), 32'h1234_5678, 32'h0, 8'(n), "R8");
            end
        end

        // R12: in_valid low ignores opcode and operands
        @(negedge clk);
        in_valid = 1'b0; op = 8'h10; opnd_a = 32'h1111_1111; opnd_b = 32'h2222_2222; imm = 8'h33;
        @(negedge clk);
        chk("R12 out_valid", {31'h0, out_valid}, 32'h0);
        chk("R12 wr_en", {31'h0, wr_en}, 32'h0);
        chk("R12 result", result, 32'h0);

        // R1: one-cycle latency after a gap
        in_valid = 1'b1; op = 8'h00; opnd_a = 32'h10; imm = 8'h05;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 latency result", result, 32'h15);
        @(negedge clk);
        chk("R1 drain out_valid", {31'h0, out_valid}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule